// File: doc/BRIEF.md
# Asynchronous SRAM Write-Timing Monitor

A passive observer for the pins of an asynchronous 16-bit static RAM port. It has no drive path onto the bus. Every control, address and data pin is sampled on a fast reference clock, and each sample is classified as standby, output-off, read or write, with the byte lanes involved. The clock is much faster than the memory cycle, so every timing figure is a count of sample ticks.

A write window needs four things at once: the active-low select, the active-high select, the write strobe, and at least one byte-lane strobe. The window opens on the sample where the last of these becomes true. It closes on the first sample where any of them is false. When a window closes, four measurements are compared with parameter minimums:

- pulse width;
- select run before the end;
- address stability before the end;
- data stability before the end.

Each violated minimum raises a one-cycle error bit and a matching sticky bit. The sticky bits are held until a synchronous clear.

Top module: `sram_wr_timing_mon`

## Requirements
- R1: `op_o` encodes the sample class as follows: 0 standby, 1 output-off, 2 read both lanes, 3 read low lane, 4 read high lane, 5 write both lanes, 6 write low lane, 7 write high lane.
  - Standby applies when `sel_a_n_i`=1, `sel_b_i`=0, or both lane strobes are 1.
  - Otherwise `wr_n_i`=0 gives a write, and `oe_n_i`=1 gives output-off.
  - Otherwise the sample is a read.
  - The lane is picked by `lo_n_i` (bits 7:0) and `hi_n_i` (bits 15:8), both active low.
- R2: `op_o` and `wr_active_o` reflect the pins sampled at the previous rising clock edge.
- R3: The pulse width is the number of samples from the last strobe becoming active to the first becoming inactive. If it is below `MIN_WP_TICKS`, error bit 0 is set.
- R4: The select run is the number of consecutive samples with both selects active, counted up to the last sample of the window. If it is below `MIN_SEL_TICKS`, error bit 1 is set.
- R5: Error bit 2 is set when the address has been unchanged for fewer than `MIN_ADR_TICKS` samples at the end of the window. It is also set when the address changed after the window opened.
- R6: If the data bus has been unchanged for fewer than `MIN_DAT_TICKS` samples at the end of the window, error bit 3 is set.
- R7: `err_o` is nonzero only for the single cycle after the cycle in which `wr_active_o` falls, and is zero at all other times.
- R8: Each `sticky_o` bit is set together with its `err_o` bit and held until `clr_i` is sampled high. A set in the same cycle as a clear wins.
- R9: A window already open when reset is released is not checked. Checking begins after one inactive sample has been seen.
- R10: During reset, `op_o` is 0, and `wr_active_o`, `err_o` and `sticky_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the sticky bits |
| sel_a_n_i | input | 1 | Active-low chip select |
| sel_b_i | input | 1 | Active-high chip select |
| wr_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| lo_n_i | input | 1 | Low byte lane strobe, active low |
| hi_n_i | input | 1 | High byte lane strobe, active low |
| addr_i | input | ADDR_W | Address pins |
| data_i | input | DATA_W | Data pins |
| op_o | output | 3 | Class of the previous sample (R1) |
| wr_active_o | output | 1 | Previous sample was inside a write window |
| err_o | output | 4 | One-cycle violation bits: 0 width, 1 select, 2 address, 3 data |
| sticky_o | output | 4 | Held violation bits, same order |

## Verification
The class and window outputs follow the pins by one edge. The bench therefore drives at a falling edge and checks them at the next falling edge.

The error bits come one edge later than the window output. For a write whose first inactive sample is driven on tick `e`, the bench samples `err_o` exactly at the falling edge of tick `e+2`. Any nonzero value at any other tick counts as a stray pulse. The sticky bits are compared with a running model once each write has fully drained.

// File: rtl/smon_pkg.sv
package smon_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_OUT_OFF = 3'd1,
    OP_RD_BOTH = 3'd2,
    OP_RD_LO   = 3'd3,
    OP_RD_HI   = 3'd4,
    OP_WR_BOTH = 3'd5,
    OP_WR_LO   = 3'd6,
    OP_WR_HI   = 3'd7
  } op_e;

  typedef struct packed {
    logic sa_n;
    logic sb;
    logic wr_n;
    logic oe_n;
    logic lo_n;
    logic hi_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{sa_n: 1'b1, sb: 1'b0, wr_n: 1'b1,
                                oe_n: 1'b1, lo_n: 1'b1, hi_n: 1'b1};

  localparam int NCHK    = 4;
  localparam int CHK_WP  = 0;
  localparam int CHK_SEL = 1;
  localparam int CHK_ADR = 2;
  localparam int CHK_DAT = 3;

  function automatic logic sel_on(ctl_t c);
    return !c.sa_n && c.sb;
  endfunction

  function automatic logic wr_on(ctl_t c);
    return sel_on(c) && !c.wr_n && (!c.lo_n || !c.hi_n);
  endfunction

  function automatic op_e classify(ctl_t c);
    op_e r;
    if (!sel_on(c) || (c.lo_n && c.hi_n)) begin
      r = OP_STANDBY;
    end else if (!c.wr_n) begin
      if (!c.lo_n && !c.hi_n) r = OP_WR_BOTH;
      else if (!c.lo_n)       r = OP_WR_LO;
      else                    r = OP_WR_HI;
    end else if (c.oe_n) begin
      r = OP_OUT_OFF;
    end else begin
      if (!c.lo_n && !c.hi_n) r = OP_RD_BOTH;
      else if (!c.lo_n)       r = OP_RD_LO;
      else                    r = OP_RD_HI;
    end
    return r;
  endfunction

endpackage

// File: rtl/smon_sampler.sv
module smon_sampler
  import smon_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output ctl_t              ctl1_o,
  output logic [ADDR_W-1:0] addr1_o,
  output logic [DATA_W-1:0] data1_o,
  output ctl_t              ctl2_o,
  output logic [ADDR_W-1:0] addr2_o,
  output logic [DATA_W-1:0] data2_o,
  output logic              v1_o,
  output logic              v2_o
);

  // stage 1 captures the pins, stage 2 keeps the prior sample for edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl1_o  <= CTL_IDLE;
      ctl2_o  <= CTL_IDLE;
      addr1_o <= '0;
      addr2_o <= '0;
      data1_o <= '0;
      data2_o <= '0;
      v1_o    <= 1'b0;
      v2_o    <= 1'b0;
    end else begin
      ctl1_o  <= ctl_i;
      addr1_o <= addr_i;
      data1_o <= data_i;
      ctl2_o  <= ctl1_o;
      addr2_o <= addr1_o;
      data2_o <= data1_o;
      v1_o    <= 1'b1;
      v2_o    <= v1_o;
    end
  end

  // R10
  valid_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_o |-> v1_o);

endmodule

// File: rtl/smon_run_cnt.sv
module smon_run_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         zero_i,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_d;

  always_comb begin
    if (zero_i)              cnt_d = '0;
    else if (restart_i)      cnt_d = W'(1);
    else if (cnt_o == CMAX)  cnt_d = CMAX;
    else                     cnt_d = cnt_o + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end

endmodule

// File: rtl/smon_window.sv
module smon_window
  import smon_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctl_t          ctl1_i,
  input  ctl_t          ctl2_i,
  input  logic          v1_i,
  output logic          wact_o,
  output logic          end_o,
  output logic [CW-1:0] pw_cnt_o,
  output logic [CW-1:0] sel_cnt_o
);

  logic wact1, wact2, start, fin;
  logic armed_q, ok_q;

  assign wact1  = wr_on(ctl1_i);
  assign wact2  = wr_on(ctl2_i);
  assign start  = wact1 && !wact2;
  assign fin    = wact2 && !wact1;
  assign wact_o = wact1;
  assign end_o  = fin && ok_q;

  smon_run_cnt #(.W(CW)) u_pw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zero_i   (!wact1),
    .restart_i(1'b0),
    .cnt_o    (pw_cnt_o)
  );

  smon_run_cnt #(.W(CW)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zero_i   (!sel_on(ctl1_i)),
    .restart_i(1'b0),
    .cnt_o    (sel_cnt_o)
  );

  // arm on the first inactive sample after reset; a window counts only if opened while armed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      armed_q <= armed_q | (v1_i & ~wact1);
      if (start)    ok_q <= armed_q;
      else if (fin) ok_q <= 1'b0;
    end
  end

  // R3
  pw_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wact2 |-> (pw_cnt_o != '0));

  // R9
  end_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> armed_q);

endmodule

// File: rtl/sram_wr_timing_mon.sv
module sram_wr_timing_mon
  import smon_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int MIN_WP_TICKS  = 5,
  parameter int MIN_SEL_TICKS = 6,
  parameter int MIN_ADR_TICKS = 6,
  parameter int MIN_DAT_TICKS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sel_a_n_i,
  input  logic              sel_b_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic              lo_n_i,
  input  logic              hi_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [2:0]        op_o,
  output logic              wr_active_o,
  output logic [3:0]        err_o,
  output logic [3:0]        sticky_o
);

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LIM = max2(max2(MIN_WP_TICKS, MIN_SEL_TICKS),
                                max2(MIN_ADR_TICKS, MIN_DAT_TICKS));
  localparam int CW = $clog2(MAX_LIM + 1) + 2;
  localparam logic [CW-1:0] LIM_WP  = CW'(MIN_WP_TICKS);
  localparam logic [CW-1:0] LIM_SEL = CW'(MIN_SEL_TICKS);
  localparam logic [CW-1:0] LIM_ADR = CW'(MIN_ADR_TICKS);
  localparam logic [CW-1:0] LIM_DAT = CW'(MIN_DAT_TICKS);

  ctl_t ctl_in, ctl1, ctl2;
  logic [ADDR_W-1:0] addr1, addr2;
  logic [DATA_W-1:0] data1, data2;
  logic v1, v2;
  logic win_end;
  logic [CW-1:0] pw_cnt, sel_cnt, adr_cnt, dat_cnt;
  logic [NCHK-1:0] bad, err_d, err_q, stk_q;

  always_comb begin
    ctl_in.sa_n = sel_a_n_i;
    ctl_in.sb   = sel_b_i;
    ctl_in.wr_n = wr_n_i;
    ctl_in.oe_n = oe_n_i;
    ctl_in.lo_n = lo_n_i;
    ctl_in.hi_n = hi_n_i;
  end

  smon_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl_in),
    .addr_i (addr_i),
    .data_i (data_i),
    .ctl1_o (ctl1),
    .addr1_o(addr1),
    .data1_o(data1),
    .ctl2_o (ctl2),
    .addr2_o(addr2),
    .data2_o(data2),
    .v1_o   (v1),
    .v2_o   (v2)
  );

  smon_window #(.CW(CW)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl1_i   (ctl1),
    .ctl2_i   (ctl2),
    .v1_i     (v1),
    .wact_o   (wr_active_o),
    .end_o    (win_end),
    .pw_cnt_o (pw_cnt),
    .sel_cnt_o(sel_cnt)
  );

  smon_run_cnt #(.W(CW)) u_adr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zero_i   (1'b0),
    .restart_i(!v2 || (addr1 != addr2)),
    .cnt_o    (adr_cnt)
  );

  smon_run_cnt #(.W(CW)) u_dat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .zero_i   (1'b0),
    .restart_i(!v2 || (data1 != data2)),
    .cnt_o    (dat_cnt)
  );

  assign op_o = classify(ctl1);

  // counters hold the values of the last in-window sample when win_end fires
  always_comb begin
    bad          = '0;
    bad[CHK_WP]  = pw_cnt < LIM_WP;
    bad[CHK_SEL] = sel_cnt < LIM_SEL;
    bad[CHK_ADR] = (adr_cnt < LIM_ADR) || (adr_cnt < pw_cnt);
    bad[CHK_DAT] = dat_cnt < LIM_DAT;
    err_d        = win_end ? bad : '0;
  end

  for (genvar i = 0; i < NCHK; i++) begin : g_chk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        err_q[i] <= 1'b0;
        stk_q[i] <= 1'b0;
      end else begin
        err_q[i] <= err_d[i];
        stk_q[i] <= (stk_q[i] & ~clr_i) | err_d[i];
      end
    end
  end

  assign err_o    = err_q;
  assign sticky_o = stk_q;

  // R7
  err_after_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != '0) |-> $past(win_end));

  // R8
  sticky_follows_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q & ~stk_q) == '0);

  // R8
  clr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && (err_d == '0)) |=> (stk_q == '0));

  // R1
  write_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o >= 3'd5) |-> wr_active_o);

endmodule

// File: tb/sram_wr_timing_mon_test.sv
module sram_wr_timing_mon_test;

  localparam int MWP = 5, MSEL = 6, MADR = 6, MDAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic sa_n = 1'b1, sb = 1'b0, wr_n = 1'b1, oe_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
  logic [17:0] addr = '0;
  logic [15:0] data = '0;
  logic [2:0] op;
  logic wact;
  logic [3:0] err, stk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] exp_stk = '0;

  always #10 clk = ~clk;

  sram_wr_timing_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .sel_a_n_i(sa_n), .sel_b_i(sb), .wr_n_i(wr_n), .oe_n_i(oe_n),
    .lo_n_i(lo_n), .hi_n_i(hi_n), .addr_i(addr), .data_i(data),
    .op_o(op), .wr_active_o(wact), .err_o(err), .sticky_o(stk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_op(logic a, logic b, logic w, logic o, logic l, logic h);
    if (a || !b || (l && h)) return 0;
    if (!w) return (!l && !h) ? 5 : (!l ? 6 : 7);
    if (o) return 1;
    return (!l && !h) ? 2 : (!l ? 3 : 4);
  endfunction

  function automatic int mx3(int a, int b, int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  function automatic int mn3(int a, int b, int c);
    int m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  function automatic logic [3:0] exp_err(int s, int e, int c0, int a0, int am, int d0);
    logic [3:0] r;
    int pw = e - s;
    int ac = (am > 0 && am < e) ? e - am : e - a0;
    r[0] = pw < MWP;
    r[1] = (e - c0) < MSEL;
    r[2] = (ac < MADR) || (ac < pw);
    r[3] = (e - d0) < MDAT;
    return r;
  endfunction

  task automatic idle_drive();
    sa_n = 1'b1; sb = 1'b0; wr_n = 1'b1; oe_n = 1'b1; lo_n = 1'b1; hi_n = 1'b1;
  endtask

  task automatic run_wr(input int w0, we_e, c0, c_e, b0, b_e, a0, am, d0,
                        input int lanes, input bit clr_at_err, input string tag);
    int s = mx3(w0, c0, b0);
    int e = mn3(we_e, c_e, b_e);
    int last = mx3(we_e, c_e, b_e) + 3;
    int stray = 0;
    logic [3:0] got = '0;
    logic [3:0] ex = exp_err(s, e, c0, a0, am, d0);
    logic [17:0] a_new = 18'($urandom);
    logic [17:0] a_old = a_new ^ 18'h15555;
    logic [15:0] d_new = 16'($urandom);
    logic [15:0] d_old = ~d_new;
    for (int t = 0; t <= last; t++) begin
      @(negedge clk);
      if (t == e + 2) got = err;
      else if (err != '0) stray++;
      sa_n = !(t >= c0 && t < c_e);
      sb   = (t >= c0 && t < c_e);
      wr_n = !(t >= w0 && t < we_e);
      oe_n = 1'b1;
      lo_n = !(t >= b0 && t < b_e && lanes[0]);
      hi_n = !(t >= b0 && t < b_e && lanes[1]);
      addr = (t < a0) ? a_old : ((am > 0 && t >= am) ? (a_new ^ 18'h1) : a_new);
      data = (t < d0) ? d_old : d_new;
      clr  = clr_at_err && (t == e + 1);
    end
    clr = 1'b0;
    exp_stk = clr_at_err ? ex : (exp_stk | ex);
    chk(got[0] == ex[0], {"R3 width ", tag}, got[0], ex[0]);
    chk(got[1] == ex[1], {"R4 select ", tag}, got[1], ex[1]);
    chk(got[2] == ex[2], {"R5 address ", tag}, got[2], ex[2]);
    chk(got[3] == ex[3], {"R6 data ", tag}, got[3], ex[3]);
    chk(stray == 0, {"R7 stray pulse ", tag}, stray, 0);
    @(negedge clk);
    chk(stk == exp_stk, {"R8 sticky ", tag}, stk, exp_stk);
  endtask

  task automatic clear_sticky();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_stk = '0;
    chk(stk == 4'h0, "R8 clear", stk, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    idle_drive();
    repeat (3) @(negedge clk);
    // R10
    chk(op == 3'd0, "R10 reset op", op, 0);
    chk(wact == 1'b0, "R10 reset wr_active", wact, 0);
    chk(err == 4'h0, "R10 reset err", err, 0);
    chk(stk == 4'h0, "R10 reset sticky", stk, 0);
    rst_n = 1'b1;

    // R1 R2: random pin states, class due one edge later
    for (int i = 0; i < 60; i++) begin
      logic [5:0] r = 6'($urandom);
      @(negedge clk);
      sa_n = r[0]; sb = r[1]; wr_n = r[2]; oe_n = r[3]; lo_n = r[4]; hi_n = r[5];
      @(negedge clk);
      chk(op == 3'(exp_op(r[0], r[1], r[2], r[3], r[4], r[5])), "R1 op class", op,
          exp_op(r[0], r[1], r[2], r[3], r[4], r[5]));
      chk(wact == (exp_op(r[0], r[1], r[2], r[3], r[4], r[5]) >= 5), "R2 wr_active",
          wact, exp_op(r[0], r[1], r[2], r[3], r[4], r[5]) >= 5);
    end
    idle_drive();
    repeat (4) @(negedge clk);
    clear_sticky();

    // directed corners
    run_wr(2, 7, 1, 9, 2, 9, 1, 0, 4, 3, 0, "exact minimums");
    run_wr(3, 7, 1, 9, 2, 9, 1, 0, 4, 1, 0, "width one short");
    run_wr(1, 10, 3, 11, 1, 9, 1, 0, 5, 2, 0, "select last, lanes first");
    run_wr(1, 9, 1, 10, 1, 10, 1, 4, 2, 3, 0, "address moves in window");
    run_wr(2, 7, 2, 9, 2, 9, 1, 0, 4, 3, 0, "select one short");
    run_wr(1, 9, 1, 9, 1, 11, 1, 0, 7, 3, 0, "data late, closed by selects");
    run_wr(2, 4, 1, 9, 1, 9, 1, 0, 3, 3, 1, "set beats clear");
    clear_sticky();

    // constrained random windows
    for (int i = 0; i < 150; i++) begin
      int w0 = 1 + int'($urandom_range(3));
      int c0 = 1 + int'($urandom_range(3));
      int b0 = 1 + int'($urandom_range(3));
      int s = mx3(w0, c0, b0);
      int e = s + 1 + int'($urandom_range(8));
      int k = int'($urandom_range(2));
      int we_e = (k == 0) ? e : e + 1 + int'($urandom_range(1));
      int c_e  = (k == 1) ? e : e + 1 + int'($urandom_range(1));
      int b_e  = (k == 2) ? e : e + 1 + int'($urandom_range(1));
      int a0 = 1 + int'($urandom_range(s + 1));
      int am = ($urandom_range(3) == 0) ? s + int'($urandom_range(e - s - 1)) : 0;
      int d0 = 1 + int'($urandom_range(e - 2));
      int ln = 1 + int'($urandom_range(2));
      if (a0 >= e) a0 = e - 1;
      if (am == s) am = 0;
      run_wr(w0, we_e, c0, c_e, b0, b_e, a0, am, d0, ln, 0, "random");
      if (i % 25 == 24) clear_sticky();
    end

    // R9: window already open at reset release is not checked
    @(negedge clk);
    rst_n = 1'b0;
    sa_n = 1'b0; sb = 1'b1; wr_n = 1'b0; lo_n = 1'b0; hi_n = 1'b0;
    exp_stk = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    begin
      int seen = 0;
      @(negedge clk);
      @(negedge clk);
      wr_n = 1'b1;
      for (int t = 0; t < 5; t++) begin
        @(negedge clk);
        if (err != '0) seen++;
      end
      chk(seen == 0, "R9 open at reset unchecked", seen, 0);
      chk(stk == 4'h0, "R9 sticky after unchecked window", stk, 0);
    end
    idle_drive();
    run_wr(1, 3, 1, 9, 1, 9, 1, 0, 1, 3, 0, "R9 armed afterwards");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule